// File: doc/BRIEF.md
# Shared Prescaler Clock Selector

This block produces the count-enable strobes for a group of timer channels. A single prescaler counter runs freely on the system clock and offers four divided taps: divide by 8, 64, 256 and 1024. Each channel has a 3-bit select input. The select chooses one of four sources for that channel's strobe: nothing, every system cycle, one of the divided taps, or an edge on the channel's own external pin. Each strobe is one system cycle wide. The timer counter that consumes a strobe increments on the clock edge that ends the strobe cycle.

The prescaler does not restart when a channel changes its select. The delay from enabling a channel to its first divided count therefore depends on where the shared counter happens to be at that moment. A single prescaler clear input sets the shared counter to zero. This realigns every channel that uses a divided tap at the same time.

Each external pin first passes through a negative-edge capture stage, which models a latch that is open while the clock is high. Two rising-edge flops follow, and then an edge detector whose polarity is set by the select.

Top module: `presc_clock_select`

## Requirements
- R1: While `rst` is high all strobes are low. A channel whose select is 0 never strobes.
- R2: With select 1 the channel strobe is high in every cycle outside reset.
- R3: Selects 2, 3, 4 and 5 give a divide-by-8, 64, 256 and 1024 strobe. Each strobe is exactly one cycle wide and repeats exactly every N cycles.
- R4: A high `presc_clr` sampled at a clock edge zeroes the shared counter. Count the cycle after that edge as cycle 1. The first divide-by-N strobe is then high in cycle N.
- R5: The prescaler runs freely. Changing a channel's select does not restart it, so the first strobe after a switch to a tap follows the shared counter phase.
- R6: A prescaler clear realigns every channel on a divided tap at once.
- R7: With select 7, each rising edge on the channel's pin gives exactly one strobe. Falling edges give none.
- R8: With select 6, each falling edge on the channel's pin gives exactly one strobe. Rising edges give none.
- R9: Suppose a pin change happens in the first half of the cycle that begins at edge k. The strobe is then high in the cycle that begins at edge k+2. A change in the second half moves the strobe to edge k+3. The consuming counter therefore updates 2.5 to 3.5 cycles after the pin edge.
- R10: Channels are independent. Each channel's strobe depends only on its own select, its own pin and the shared counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_clr | input | 1 | Clears the shared prescaler counter |
| ext_pin | input | NUM_CH | External count pins, one per channel |
| chan_sel | input | NUM_CH x 3 | Per-channel source select (0 off, 1 system clock, 2..5 divided taps, 6 falling pin edge, 7 rising pin edge) |
| cnt_en | output | NUM_CH | Per-channel one-cycle count-enable strobe |

## Verification
The bench measures the first strobe after a prescaler clear and the spacing of the next strobe on every tap. A counter wired to the wrong low bits, or cleared one cycle late, moves those positions. It switches a channel onto a tap at a known counter phase. A design that restarts the prescaler on a select change would strobe N cycles later instead of at the shared phase. It drives pin edges in both halves of a cycle and expects strobes exactly two or three cycles later. It also checks that the other polarity stays silent. This catches a missing capture stage, an extra flop, and swapped edge polarity.

// File: rtl/presc_pkg.sv
package presc_pkg;

    localparam int NUM_TAPS = 4;

    typedef enum logic [2:0] {
        SRC_OFF      = 3'd0,
        SRC_SYS      = 3'd1,
        SRC_DIV8     = 3'd2,
        SRC_DIV64    = 3'd3,
        SRC_DIV256   = 3'd4,
        SRC_DIV1024  = 3'd5,
        SRC_PIN_FALL = 3'd6,
        SRC_PIN_RISE = 3'd7
    } clk_src_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } pin_edge_t;

    // number of low counter bits that must be all ones for tap t
    function automatic int tap_bits(input int t);
        case (t)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

    localparam int PRESC_W = tap_bits(NUM_TAPS - 1);

endpackage

// File: rtl/presc_divider.sv
module presc_divider
    import presc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_i,
    output logic [NUM_TAPS-1:0] tap_o
);
    logic [PRESC_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        localparam int B = tap_bits(t);
        assign tap_o[t] = &cnt_q[B-1:0];

        // R3: a tap strobe never lasts two cycles
        assert_tap_width_R3: assert property (@(posedge clk) disable iff (rst)
            tap_o[t] |=> !tap_o[t]);
    end

    // R4: the cycle after a clear carries no tap strobe
    assert_clear_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (tap_o == '0));

endmodule

// File: rtl/presc_pin_edge.sv
module presc_pin_edge
    import presc_pkg::*;
#(
    parameter int SYNC_FLOPS = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_i,
    output pin_edge_t edge_o
);
    logic                  cap_q;
    logic [SYNC_FLOPS-1:0] sync_q;
    logic                  hist_q;
    logic                  cur;

    // capture while the clock is high: modelled on the falling edge
    always_ff @(negedge clk) begin
        if (rst) begin
            cap_q <= 1'b0;
        end else begin
            cap_q <= pin_i;
        end
    end

    for (genvar i = 0; i < SYNC_FLOPS; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sync_q[0] <= 1'b0;
                else     sync_q[0] <= cap_q;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sync_q[i] <= 1'b0;
                else     sync_q[i] <= sync_q[i-1];
            end
        end
    end

    assign cur = sync_q[SYNC_FLOPS-1];

    always_ff @(posedge clk) begin
        if (rst) hist_q <= 1'b0;
        else     hist_q <= cur;
    end

    always_comb begin
        edge_o.rise = cur & ~hist_q;
        edge_o.fall = ~cur & hist_q;
    end

    // R7, R8: one-cycle pulses, never both polarities together
    assert_edge_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({edge_o.rise, edge_o.fall}));
    assert_rise_single_R7: assert property (@(posedge clk) disable iff (rst)
        edge_o.rise |=> !edge_o.rise);

endmodule

// File: rtl/presc_chan_mux.sv
module presc_chan_mux
    import presc_pkg::*;
(
    input  logic [2:0]          sel_i,
    input  logic [NUM_TAPS-1:0] tap_i,
    input  pin_edge_t           edge_i,
    output logic                en_o
);
    clk_src_e src;

    always_comb begin
        src = clk_src_e'(sel_i);
        unique case (src)
            SRC_OFF:      en_o = 1'b0;
            SRC_SYS:      en_o = 1'b1;
            SRC_DIV8:     en_o = tap_i[0];
            SRC_DIV64:    en_o = tap_i[1];
            SRC_DIV256:   en_o = tap_i[2];
            SRC_DIV1024:  en_o = tap_i[3];
            SRC_PIN_FALL: en_o = edge_i.fall;
            SRC_PIN_RISE: en_o = edge_i.rise;
            default:      en_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/presc_clock_select.sv
module presc_clock_select
    import presc_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int SYNC_FLOPS = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  presc_clr,
    input  logic [NUM_CH-1:0]     ext_pin,
    input  logic [NUM_CH-1:0][2:0] chan_sel,
    output logic [NUM_CH-1:0]     cnt_en
);
    logic [NUM_TAPS-1:0] taps;
    logic [NUM_CH-1:0]   en_raw;

    presc_divider u_div (
        .clk   (clk),
        .rst   (rst),
        .clr_i (presc_clr),
        .tap_o (taps)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pin_edge_t edges;

        presc_pin_edge #(.SYNC_FLOPS(SYNC_FLOPS)) u_edge (
            .clk    (clk),
            .rst    (rst),
            .pin_i  (ext_pin[c]),
            .edge_o (edges)
        );

        presc_chan_mux u_mux (
            .sel_i  (chan_sel[c]),
            .tap_i  (taps),
            .edge_i (edges),
            .en_o   (en_raw[c])
        );

        // R2: system-clock select strobes every cycle
        assert_sys_strobe_R2: assert property (@(posedge clk) disable iff (rst)
            (chan_sel[c] == 3'd1) |-> cnt_en[c]);
        // R1: an off channel stays silent
        assert_off_silent_R1: assert property (@(posedge clk) disable iff (rst)
            (chan_sel[c] == 3'd0) |-> !cnt_en[c]);
    end

    assign cnt_en = rst ? '0 : en_raw;

    // R1: no strobe in reset
    always_comb begin
        if (rst) assert_reset_quiet_R1: assert (cnt_en == '0);
    end

endmodule

// File: tb/presc_clock_select_tb.sv
`timescale 1ns/1ps
module presc_clock_select_tb;
    localparam int NCH = 4;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 presc_clr = 1'b0;
    logic [NCH-1:0]       ext_pin = '0;
    logic [NCH-1:0][2:0]  chan_sel = '0;
    logic [NCH-1:0]       cnt_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    presc_clock_select #(.NUM_CH(NCH), .SYNC_FLOPS(2)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .presc_clr (presc_clr),
        .ext_pin   (ext_pin),
        .chan_sel  (chan_sel),
        .cnt_en    (cnt_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // clear is sampled on the next edge; returns just after it (k = 0)
    task automatic clear_presc();
        @(posedge clk); #1 presc_clr = 1'b1;
        @(posedge clk); #1 presc_clr = 1'b0;
    endtask

    task automatic t_reset();
        chan_sel = '0;
        chan_sel[0] = 3'd1;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #3 check(cnt_en == '0, "R1 reset quiet", int'(cnt_en), 0);
        @(posedge clk); #1 rst = 1'b0; chan_sel = '0;
        begin
            int hits = 0;
            for (int k = 0; k < 40; k++) begin
                @(posedge clk); #3 if (cnt_en != '0) hits++;
            end
            check(hits == 0, "R1 select 0 silent", hits, 0);
        end
    endtask

    task automatic t_sys();
        int lows = 0;
        @(posedge clk); #1 chan_sel[0] = 3'd1;
        for (int k = 0; k < 30; k++) begin
            @(posedge clk); #3 if (!cnt_en[0]) lows++;
        end
        check(lows == 0, "R2 strobe every cycle", lows, 0);
        @(posedge clk); #1 chan_sel[0] = 3'd0;
    endtask

    // R3/R4: first strobe at k = N-1 after clear edge, next at 2N-1
    task automatic t_tap(input int code, input int n);
        int first = -1, second = -1, hits = 0;
        @(posedge clk); #1 chan_sel[0] = 3'(code);
        clear_presc();
        #2 if (cnt_en[0]) hits++;
        for (int k = 1; k <= 2*n + 2; k++) begin
            @(posedge clk); #3
            if (cnt_en[0]) begin
                hits++;
                if (first < 0) first = k;
                else if (second < 0) second = k;
            end
        end
        check(first == n - 1, "R4 first strobe after clear", first, n - 1);
        check(second - first == n, "R3 strobe period", second - first, n);
        check(hits == 2, "R3 single-cycle strobes", hits, 2);
        @(posedge clk); #1 chan_sel[0] = 3'd0;
    endtask

    // R5: switching select mid-phase follows the shared counter
    task automatic t_free_run();
        int first = -1;
        clear_presc();
        for (int k = 1; k <= 13; k++) @(posedge clk);
        #1 chan_sel[1] = 3'd2;
        #2 if (cnt_en[1] && first < 0) first = 13;
        for (int k = 14; k <= 30; k++) begin
            @(posedge clk); #3 if (cnt_en[1] && first < 0) first = k;
        end
        check(first == 15, "R5 free-running phase", first, 15);
        @(posedge clk); #1 chan_sel[1] = 3'd0;
    endtask

    // R6 + R10: clear realigns two taps; other channels unaffected
    task automatic t_multi();
        int f8 = -1, f64 = -1, n8 = 0, sys_low = 0, off_hi = 0;
        @(posedge clk); #1
        chan_sel[0] = 3'd2; chan_sel[1] = 3'd3; chan_sel[2] = 3'd1; chan_sel[3] = 3'd0;
        repeat (21) @(posedge clk);
        clear_presc();
        for (int k = 1; k <= 64; k++) begin
            @(posedge clk); #3
            if (cnt_en[0]) begin n8++; if (f8 < 0) f8 = k; end
            if (cnt_en[1] && f64 < 0) f64 = k;
            if (!cnt_en[2]) sys_low++;
            if (cnt_en[3]) off_hi++;
        end
        check(f8 == 7,  "R6 div8 realigned", f8, 7);
        check(f64 == 63, "R6 div64 realigned", f64, 63);
        check(n8 == 8, "R10 div8 count", n8, 8);
        check(sys_low == 0, "R10 sys channel", sys_low, 0);
        check(off_hi == 0, "R10 off channel", off_hi, 0);
        @(posedge clk); #1 chan_sel = '0;
    endtask

    // R7/R8/R9: ch2 rising, ch3 falling, both pins driven together
    task automatic t_pin(input bit level, input int dly, input int exp_k);
        int k_rise = -1, k_fall = -1, n_rise = 0, n_fall = 0;
        @(posedge clk); #(dly)
        ext_pin[2] = level; ext_pin[3] = level;
        for (int k = 1; k <= 6; k++) begin
            @(posedge clk); #3
            if (cnt_en[2]) begin n_rise++; k_rise = k; end
            if (cnt_en[3]) begin n_fall++; k_fall = k; end
        end
        if (level) begin
            check(n_rise == 1, "R7 one strobe per rising edge", n_rise, 1);
            check(n_fall == 0, "R8 falling select ignores rise", n_fall, 0);
            check(k_rise == exp_k, "R9 rise latency", k_rise, exp_k);
        end else begin
            check(n_fall == 1, "R8 one strobe per falling edge", n_fall, 1);
            check(n_rise == 0, "R7 rising select ignores fall", n_rise, 0);
            check(k_fall == exp_k, "R9 fall latency", k_fall, exp_k);
        end
    endtask

    task automatic t_ext();
        @(posedge clk); #1 chan_sel[2] = 3'd7; chan_sel[3] = 3'd6;
        repeat (4) @(posedge clk);
        t_pin(1'b1, 1, 2);
        t_pin(1'b0, 1, 2);
        t_pin(1'b1, 7, 3);
        t_pin(1'b0, 7, 3);
        @(posedge clk); #1 chan_sel = '0;
    endtask

    initial begin
        t_reset();
        t_sys();
        t_tap(2, 8);
        t_tap(3, 64);
        t_tap(4, 256);
        t_tap(5, 1024);
        t_free_run();
        t_multi();
        t_ext();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule